// File: doc/BRIEF.md
# Fixed-Point YUV-to-RGB Color Converter

This block turns a stream of 8-bit Y, U, V pixels into 8-bit R, G, B pixels. Each output channel is an affine function of the three inputs: three signed coefficients multiply Y, U and V, a signed constant is added to their sum, and the result is rounded and clamped to one byte. All twelve matrix values are 32-bit two's complement numbers with 10 fractional bits. Out of reset they hold the limited-range standard-definition conversion matrix.

A configuration port writes the twelve values into a staging copy, which can be read back at any time. The staged values move into the copy used by the arithmetic only when a beat marked as start of frame is accepted. That beat is already converted with the new values, so no frame ever mixes two matrices. The chroma-order input is sampled at the same moment. In swapped order the two chroma coefficient columns are exchanged. An unsupported order value leaves the running matrix alone and raises a sticky error flag.

Pixels move with a valid/ready handshake through three register stages: multiply, sum, then round and clamp. The whole pipeline holds its contents when the consumer stalls.

Top module: `pix_colorconv`

## Requirements
- R1: The configuration port addresses twelve 32-bit words at addresses 0 to 11. Rows are ordered R (0-3), G (4-7), B (8-11). Within each row the order is the Y coefficient, the U coefficient, the V coefficient, then the constant. `cfgRdData` returns the staged word at `cfgAddr` combinationally and shows a write on the cycle after it. Addresses 12 to 15 read as 0, and writes to them are ignored.
- R2: After reset the staged and running matrices are R row {0x4A8, 0x0, 0x662, 0xFFFC845A}, G row {0x4A8, 0xFFFFFE6F, 0xFFFFFCBF, 0x00021DF4}, B row {0x4A8, 0x813, 0x0, 0xFFFBAC4A}.
- R3: Each output channel equals clamp(((cY*Y + cU*U + cV*V + k) + 512) >>> 10). Y, U and V are unsigned integers, and the coefficients and constant are signed with 10 fractional bits.
- R4: A beat accepted at clock edge n is presented with `outValid` high after edge n+2, and `outValid` is low between those edges when nothing else is in flight.
- R5: `chromaOrder` = 0 selects YUV, so the matrix is used as written. A value of 1 selects YVU: the second and third coefficients of every row are exchanged, and the constants are left unchanged.
- R6: Configuration writes do not affect pixels until a beat with `inSof` high is accepted. That beat and all later ones use the staged values.
- R7: If a start-of-frame beat is accepted while `chromaOrder` is 2 or 3, the running matrix is kept and `cfgErr` goes high and stays high until reset.
- R8: Rounding is half-up. An exact fraction of one half rounds toward the larger integer.
- R9: Results below 0 output 0, and results above 255 output 255.
- R10: While `outValid` is high and `outReady` is low, the outputs hold steady and `inReady` is low once all three stages are full. Every accepted beat leaves exactly once, in order.
- R11: During and right after reset, `outValid` and `cfgErr` are low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Word address for write and read |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Staged word at `cfgAddr` |
| chromaOrder | input | 2 | 0 YUV, 1 YVU, others invalid |
| cfgErr | output | 1 | Sticky invalid-order flag |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high |
| inSof | input | 1 | Input beat starts a frame |
| inY | input | 8 | Luma |
| inU | input | 8 | First chroma component |
| inV | input | 8 | Second chroma component |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Consumer ready |
| outR | output | 8 | Red |
| outG | output | 8 | Green |
| outB | output | 8 | Blue |

## Verification
A table of colors is driven through the default matrix in both chroma orders. It includes dark, bright and saturated pixels and extreme component values. Because U and V carry different weights, a swapped column shows up as a wrong channel. Custom matrices with half-valued coefficients separate half-up rounding from truncation, and large or negative terms reach both clamp limits. A write in the middle of a frame followed by a new frame shows whether the staged copy is committed at the right beat, and an invalid order value shows whether the running matrix is kept. A burst against a stalled consumer checks holding, ordering and input backpressure.

// File: rtl/colorconv_pkg.sv
package colorconv_pkg;
  localparam int COMP_W    = 8;
  localparam int COEF_W    = 32;
  localparam int FRAC_W    = 10;
  localparam int ROWS      = 3;
  localparam int ROW_WORDS = 4;
  localparam int NUM_WORDS = ROWS * ROW_WORDS;
  localparam int ADDR_W    = 4;

  typedef logic [NUM_WORDS-1:0][COEF_W-1:0] matrix_t;

  typedef enum logic [1:0] {
    ORDER_YUV = 2'd0,
    ORDER_YVU = 2'd1
  } chromaOrder_e;

  typedef struct packed {
    logic adv;     // all stages step forward
    logic commit;  // staged matrix becomes running matrix
  } ctrlStrobes_t;

  function automatic matrix_t defaultMatrix();
    matrix_t m;
    m[0]  = 32'h000004A8; m[1]  = 32'h00000000; m[2]  = 32'h00000662; m[3]  = 32'hFFFC845A;
    m[4]  = 32'h000004A8; m[5]  = 32'hFFFFFE6F; m[6]  = 32'hFFFFFCBF; m[7]  = 32'h00021DF4;
    m[8]  = 32'h000004A8; m[9]  = 32'h00000813; m[10] = 32'h00000000; m[11] = 32'hFFFBAC4A;
    return m;
  endfunction
endpackage

// File: rtl/colorconv_ctrl.sv
module colorconv_ctrl
  import colorconv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [COEF_W-1:0] cfgWrData,
  output logic [COEF_W-1:0] cfgRdData,
  input  logic [1:0]        chromaOrder,
  output logic              cfgErr,
  input  logic              inValid,
  input  logic              inSof,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output ctrlStrobes_t      strobes,
  output matrix_t           useMat
);
  localparam int STAGES = 3;

  matrix_t stagedMat;
  matrix_t activeMat;
  matrix_t orderedMat;
  logic [STAGES-1:0] stageValid;
  logic adv, fire, sofFire, orderOk, addrOk;

  assign adv     = !stageValid[STAGES-1] || outReady;
  assign fire    = inValid && adv;
  assign sofFire = fire && inSof;
  assign orderOk = (chromaOrder == ORDER_YUV) || (chromaOrder == ORDER_YVU);
  assign addrOk  = (cfgAddr < ADDR_W'(NUM_WORDS));

  // Column exchange for swapped chroma order; constants untouched.
  always_comb begin
    orderedMat = stagedMat;
    if (chromaOrder == ORDER_YVU) begin
      for (int r = 0; r < ROWS; r++) begin
        orderedMat[r*ROW_WORDS+1] = stagedMat[r*ROW_WORDS+2];
        orderedMat[r*ROW_WORDS+2] = stagedMat[r*ROW_WORDS+1];
      end
    end
  end

  assign strobes.adv    = adv;
  assign strobes.commit = sofFire && orderOk;
  assign useMat         = strobes.commit ? orderedMat : activeMat;
  assign inReady        = adv;
  assign outValid       = stageValid[STAGES-1];
  assign cfgRdData      = addrOk ? stagedMat[cfgAddr] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedMat  <= defaultMatrix();
      activeMat  <= defaultMatrix();
      cfgErr     <= 1'b0;
      stageValid <= '0;
    end else begin
      if (cfgWrEn && addrOk) stagedMat[cfgAddr] <= cfgWrData;
      if (strobes.commit) activeMat <= orderedMat;
      if (sofFire && !orderOk) cfgErr <= 1'b1;
      if (adv) stageValid <= {stageValid[STAGES-2:0], fire};
    end
  end

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  assert_bad_order_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inSof && chromaOrder[1]) |=> cfgErr);

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && addrOk) |=> (cfgAddr != $past(cfgAddr)) || (cfgRdData == $past(cfgWrData)));
endmodule

// File: rtl/colorconv_dp.sv
module colorconv_dp
  import colorconv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  matrix_t           useMat,
  input  logic [COMP_W-1:0] inY,
  input  logic [COMP_W-1:0] inU,
  input  logic [COMP_W-1:0] inV,
  output logic [COMP_W-1:0] outR,
  output logic [COMP_W-1:0] outG,
  output logic [COMP_W-1:0] outB
);
  localparam int PROD_W = COEF_W + COMP_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam logic signed [SUM_W-1:0] HALF   = SUM_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0] MAXOUT = SUM_W'((1 << COMP_W) - 1);

  logic [COMP_W-1:0] comp [3];
  logic [COMP_W-1:0] chanOut [ROWS];

  assign comp[0] = inY;
  assign comp[1] = inU;
  assign comp[2] = inV;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic signed [PROD_W-1:0] prodNext [3];
    logic signed [PROD_W-1:0] prodQ [3];
    logic signed [COEF_W-1:0] constQ;
    logic signed [SUM_W-1:0]  sumNext, sumQ, roundVal;
    logic [COMP_W-1:0]        clampNext, pixQ;

    for (genvar c = 0; c < 3; c++) begin : g_mul
      logic signed [COEF_W-1:0] coef;
      logic signed [COMP_W:0]   x;
      assign coef = useMat[r*ROW_WORDS+c];
      assign x    = {1'b0, comp[c]};
      assign prodNext[c] = PROD_W'(coef) * PROD_W'(x);
    end

    assign sumNext = SUM_W'(prodQ[0]) + SUM_W'(prodQ[1]) + SUM_W'(prodQ[2]) + SUM_W'(constQ);
    assign roundVal = (sumQ + HALF) >>> FRAC_W;

    always_comb begin
      if (roundVal < 0)            clampNext = '0;
      else if (roundVal > MAXOUT)  clampNext = '1;
      else                         clampNext = roundVal[COMP_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prodQ[0] <= '0; prodQ[1] <= '0; prodQ[2] <= '0;
        constQ   <= '0;
        sumQ     <= '0;
        pixQ     <= '0;
      end else if (strobes.adv) begin
        prodQ[0] <= prodNext[0];
        prodQ[1] <= prodNext[1];
        prodQ[2] <= prodNext[2];
        constQ   <= useMat[r*ROW_WORDS+3];
        sumQ     <= sumNext;
        pixQ     <= clampNext;
      end
    end

    assign chanOut[r] = pixQ;
  end

  assign outR = chanOut[0];
  assign outG = chanOut[1];
  assign outB = chanOut[2];
endmodule

// File: rtl/pix_colorconv.sv
module pix_colorconv
  import colorconv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [COEF_W-1:0] cfgWrData,
  output logic [COEF_W-1:0] cfgRdData,
  input  logic [1:0]        chromaOrder,
  output logic              cfgErr,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inSof,
  input  logic [COMP_W-1:0] inY,
  input  logic [COMP_W-1:0] inU,
  input  logic [COMP_W-1:0] inV,
  output logic              outValid,
  input  logic              outReady,
  output logic [COMP_W-1:0] outR,
  output logic [COMP_W-1:0] outG,
  output logic [COMP_W-1:0] outB
);
  ctrlStrobes_t strobes;
  matrix_t      useMat;

  colorconv_ctrl i_ctrl (
    .clk, .rstN, .cfgWrEn, .cfgAddr, .cfgWrData, .cfgRdData,
    .chromaOrder, .cfgErr, .inValid, .inSof, .inReady,
    .outValid, .outReady, .strobes, .useMat
  );

  colorconv_dp i_dp (
    .clk, .rstN, .strobes, .useMat, .inY, .inU, .inV, .outR, .outG, .outB
  );

  assert_hold_when_stalled_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outR) && $stable(outG) && $stable(outB));
endmodule

// File: tb/test_pix_colorconv.sv
module test_pix_colorconv;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {order bit, Y, U, V}
  localparam logic [24:0] VECS [NVEC] = '{
    {1'b0, 8'd16,  8'd128, 8'd128},
    {1'b0, 8'd235, 8'd128, 8'd128},
    {1'b0, 8'd81,  8'd90,  8'd240},
    {1'b0, 8'd41,  8'd240, 8'd110},
    {1'b0, 8'd145, 8'd54,  8'd34},
    {1'b0, 8'd0,   8'd255, 8'd0},
    {1'b0, 8'd255, 8'd0,   8'd255},
    {1'b1, 8'd81,  8'd240, 8'd90},
    {1'b1, 8'd41,  8'd110, 8'd240},
    {1'b1, 8'd200, 8'd20,  8'd230}
  };

  logic clk = 0, rstN = 0;
  logic cfgWrEn = 0;
  logic [3:0] cfgAddr = 0;
  logic [31:0] cfgWrData = 0, cfgRdData;
  logic [1:0] chromaOrder = 0;
  logic cfgErr, inValid = 0, inReady, inSof = 0;
  logic [7:0] inY = 0, inU = 0, inV = 0;
  logic outValid, outReady = 1;
  logic [7:0] outR, outG, outB;

  int checkCnt = 0, failCnt = 0;
  logic [31:0] benchStaged [12];
  logic [31:0] benchActive [12];
  logic [31:0] defaults [12] = '{32'h4A8, 32'h0, 32'h662, 32'hFFFC845A,
                                 32'h4A8, 32'hFFFFFE6F, 32'hFFFFFCBF, 32'h00021DF4,
                                 32'h4A8, 32'h813, 32'h0, 32'hFFFBAC4A};

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_colorconv i_pix_colorconv (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model(input int row, input logic [7:0] y, u, v);
    longint s, r;
    s = longint'($signed(benchActive[row*4]))   * longint'(y)
      + longint'($signed(benchActive[row*4+1])) * longint'(u)
      + longint'($signed(benchActive[row*4+2])) * longint'(v)
      + longint'($signed(benchActive[row*4+3]));
    r = (s + 512) >>> 10;
    if (r < 0) return 0;
    if (r > 255) return 255;
    return int'(r);
  endfunction

  function automatic void benchCommit(input logic [1:0] ord);
    for (int i = 0; i < 12; i++) benchActive[i] = benchStaged[i];
    if (ord == 2'd1)
      for (int r = 0; r < 3; r++) begin
        benchActive[r*4+1] = benchStaged[r*4+2];
        benchActive[r*4+2] = benchStaged[r*4+1];
      end
  endfunction

  task automatic cfgWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0;
    if (a < 12) benchStaged[a] = d;
  endtask

  // One pixel through an empty pipeline; checks latency and all channels.
  task automatic sendPixel(input logic [7:0] y, u, v, input bit sof, input string req);
    int eR, eG, eB;
    @(negedge clk);
    inValid = 1; inSof = sof; inY = y; inU = u; inV = v;
    @(posedge clk);
    if (sof && chromaOrder < 2) benchCommit(chromaOrder);
    eR = model(0, y, u, v); eG = model(1, y, u, v); eB = model(2, y, u, v);
    @(negedge clk);
    inValid = 0; inSof = 0;
    @(negedge clk);
    check(outValid == 0, "R4", "outValid early", outValid, 0);
    @(negedge clk);
    check(outValid == 1, "R4", "outValid at n+2", outValid, 1);
    check(outR == eR, req, "outR", outR, eR);
    check(outG == eG, req, "outG", outG, eG);
    check(outB == eB, req, "outB", outB, eB);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++; checkCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    int eR0, eR1, eR2;
    for (int i = 0; i < 12; i++) begin
      benchStaged[i] = defaults[i];
      benchActive[i] = defaults[i];
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    check(outValid == 0, "R11", "outValid in reset", outValid, 0);
    check(cfgErr == 0, "R11", "cfgErr in reset", cfgErr, 0);
    rstN = 1;
    @(negedge clk);
    check(inReady == 1, "R11", "inReady after reset", inReady, 1);
    check(outValid == 0, "R11", "outValid after reset", outValid, 0);
    // R2 default readback
    for (int a = 0; a < 12; a++) begin
      cfgAddr = 4'(a); #1;
      check(cfgRdData == defaults[a], "R2", $sformatf("default word %0d", a), cfgRdData, defaults[a]);
    end

    // R3/R5 table walk (each vector starts a frame)
    for (int i = 0; i < NVEC; i++) begin
      chromaOrder = {1'b0, VECS[i][24]};
      sendPixel(VECS[i][23:16], VECS[i][15:8], VECS[i][7:0], 1'b1,
                VECS[i][24] ? "R5" : "R3");
    end
    chromaOrder = 0;
    sendPixel(8'd16, 8'd128, 8'd128, 1'b1, "R5");

    // R1 out-of-range address
    cfgWrite(4'd12, 32'hDEADBEEF);
    cfgAddr = 4'd12; #1;
    check(cfgRdData == 0, "R1", "read addr 12", cfgRdData, 0);
    cfgAddr = 4'd0; #1;
    check(cfgRdData == 32'h4A8, "R1", "word 0 after bad write", cfgRdData, 32'h4A8);

    // R6: mid-frame writes are deferred; rounding matrix R8
    cfgWrite(4'd0, 32'h200); cfgWrite(4'd1, 32'h0); cfgWrite(4'd2, 32'h0); cfgWrite(4'd3, 32'h0);
    cfgWrite(4'd4, 32'h0); cfgWrite(4'd5, 32'h600); cfgWrite(4'd6, 32'h0); cfgWrite(4'd7, 32'h0);
    cfgWrite(4'd8, 32'h0); cfgWrite(4'd9, 32'h0); cfgWrite(4'd10, 32'h0); cfgWrite(4'd11, 32'hFFFFFE00);
    cfgAddr = 4'd5; #1;
    check(cfgRdData == 32'h600, "R1", "staged readback", cfgRdData, 32'h600);
    sendPixel(8'd100, 8'd50, 8'd60, 1'b0, "R6");
    check(outR != 8'd50, "R6", "old matrix still running", outR, 8'd50);
    sendPixel(8'd1, 8'd1, 8'd0, 1'b1, "R8");
    check(outR == 8'd1 && outG == 8'd2, "R8", "half-up 0.5 and 1.5", {outR, outG}, 16'h0102);
    sendPixel(8'd3, 8'd3, 8'd9, 1'b0, "R8");
    check(outR == 8'd2, "R8", "1.5 rounds to 2", outR, 2);

    // R9 clamp both ends
    cfgWrite(4'd0, 32'h00010000); cfgWrite(4'd3, 32'h0);
    cfgWrite(4'd11, 32'hFFF00000);
    sendPixel(8'd200, 8'd10, 8'd10, 1'b1, "R9");
    check(outR == 8'd255, "R9", "clamp high", outR, 255);
    check(outB == 8'd0, "R9", "clamp low", outB, 0);

    // R7 invalid order keeps matrix, error is sticky
    cfgWrite(4'd0, 32'h400);
    chromaOrder = 2'd2;
    sendPixel(8'd40, 8'd20, 8'd20, 1'b1, "R7");
    check(outR == 8'd255, "R7", "matrix kept on bad order", outR, 255);
    check(cfgErr == 1, "R7", "cfgErr set", cfgErr, 1);
    chromaOrder = 2'd0;
    sendPixel(8'd40, 8'd20, 8'd20, 1'b1, "R7");
    check(outR == 8'd40, "R7", "new matrix after good sof", outR, 40);
    check(cfgErr == 1, "R7", "cfgErr sticky", cfgErr, 1);

    // R10 backpressure burst
    eR0 = model(0, 8'd10, 8'd0, 8'd0);
    eR1 = model(0, 8'd20, 8'd0, 8'd0);
    eR2 = model(0, 8'd30, 8'd0, 8'd0);
    @(negedge clk);
    outReady = 0; inValid = 1; inY = 8'd10; inU = 0; inV = 0;
    @(negedge clk);
    check(inReady == 1, "R10", "ready stage 2", inReady, 1);
    inY = 8'd20;
    @(negedge clk);
    check(inReady == 1, "R10", "ready stage 3", inReady, 1);
    inY = 8'd30;
    @(negedge clk);
    inValid = 0;
    check(inReady == 0, "R10", "inReady low when full", inReady, 0);
    check(outValid == 1 && outR == eR0, "R10", "first held", outR, eR0);
    @(negedge clk);
    check(outValid == 1 && outR == eR0, "R10", "still held", outR, eR0);
    outReady = 1;
    @(negedge clk);
    check(outValid == 1 && outR == eR1, "R10", "second out", outR, eR1);
    @(negedge clk);
    check(outValid == 1 && outR == eR2, "R10", "third out", outR, eR2);
    @(negedge clk);
    check(outValid == 0, "R10", "drained", outValid, 0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule